// File: doc/BRIEF.md
# Sized Shift Unit with Condition Flags

This execution unit shifts the low byte, word or longword of a 32-bit data register left or right, either logically or arithmetically, and derives the five condition flags: extend (X), negative (N), zero (Z), overflow (V) and carry (C). The operation comes from a 16-bit shift instruction word. The shift count comes either from a 3-bit field inside that word or from a count-source register. A separate word-sized memory form shifts a 16-bit value by exactly one position.

The caller presents the instruction word, the destination register value, the count-source value, the current extend flag and an overflow-mode bit, and pulses `in_valid`. One clock later the unit returns the merged register value and the new flags, with `out_valid` high. In full mode, an arithmetic left shift reports any change of the sign bit during the shift. In reduced mode, overflow is always cleared.

Top module: `shift_cc_unit`

## Requirements
- R1: Instruction bit 8 selects the direction (1 left, 0 right) and bit 3 selects the kind (1 logical, 0 arithmetic). Bits 7:6 select the size (00 byte, 01 word, 10 long), and 11 selects the memory form. Bit 5 selects the count source (0 immediate field, 1 register).
- R2: An immediate count is taken from instruction bits 11:9, and the value 0 there means a count of 8.
- R3: A register count is `cnt_val` modulo 64. Counts of 0 to 63 are honoured even when they exceed the operand width: a left or logical shift then yields zero, and an arithmetic right shift yields copies of the sign bit.
- R4: Only the sized low part of `dst_val` is replaced in `result`, and the bits above it are passed through unchanged.
- R5: C is the last bit shifted out of the sized operand. A bit position beyond the width reads as zero, or as the sign bit for an arithmetic right shift.
- R6: For a nonzero count, X equals C. For a zero register count, C is 0, X keeps `x_in`, V is 0 and the sized value is unchanged.
- R7: N is the top bit of the sized result, and Z is 1 exactly when every bit of the sized result is 0.
- R8: With `full_ovf`=1, an arithmetic left shift sets V when the top count+1 bits of the original sized operand are not all equal. When count ≥ width, it sets V when the operand is nonzero.
- R9: V is 0 for every logical shift, for every right shift, and for every shift when `full_ovf`=0.
- R10: The memory form shifts the low 16 bits of `dst_val` by exactly one position, follows the same flag rules as a word shift, and ignores bit 5 and bits 11:9.
- R11: The result and flags are registered when `in_valid` is high, and `out_valid` is high exactly one cycle after `in_valid`. The outputs hold their values otherwise, and a synchronous active-high reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| instr | input | 16 | Shift instruction word |
| dst_val | input | 32 | Destination register value |
| cnt_val | input | 32 | Count-source register value |
| x_in | input | 1 | Current extend flag |
| full_ovf | input | 1 | 1: full overflow tracking, 0: overflow always cleared |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 32 | Merged register value |
| flag_x | output | 1 | Extend flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
Every result and flag is due in the first clock after the edge that sampled `in_valid`, so the bench drives stimulus on the falling edge and compares all outputs on the next falling edge. On cycles without a strobe, the bench expects `out_valid` low and every other output equal to the value last produced, so it checks the hold behaviour on every clock. The reference model reaches each result by shifting one bit per loop step and watching the sign bit, which gives an independent check of the single-step carry and overflow rules.

// File: rtl/shift_cc_unit.sv
module shift_cc_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [15:0] instr,
  input  logic [31:0] dst_val,
  input  logic [31:0] cnt_val,
  input  logic        x_in,
  input  logic        full_ovf,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        flag_x,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_v,
  output logic        flag_c
);

  logic         is_mem, go_left, is_logic;
  logic [1:0]   sz;
  logic [6:0]   width;
  logic [5:0]   cnt;
  logic [31:0]  zop, sop;
  logic [63:0]  ext64, sext64, tshift;
  logic [127:0] lsh, rsh;
  logic [31:0]  raw, merged;
  logic         c_new, v_new, n_new, z_new, x_new;

  assign is_mem   = instr[7:6] == 2'b11;
  assign go_left  = instr[8];
  assign is_logic = instr[3];
  assign sz       = is_mem ? 2'b01 : instr[7:6];
  assign width    = (sz == 2'b00) ? 7'd8 : (sz == 2'b01) ? 7'd16 : 7'd32;

  always_comb begin
    if (is_mem)              cnt = 6'd1;
    else if (instr[5])       cnt = cnt_val[5:0];
    else if (instr[11:9] == 3'd0) cnt = 6'd8;
    else                     cnt = {3'd0, instr[11:9]};
  end

  always_comb begin
    case (sz)
      2'b00:   begin zop = {24'd0, dst_val[7:0]};  sop = {{24{dst_val[7]}},  dst_val[7:0]};  end
      2'b01:   begin zop = {16'd0, dst_val[15:0]}; sop = {{16{dst_val[15]}}, dst_val[15:0]}; end
      default: begin zop = dst_val;                sop = dst_val;                            end
    endcase
  end

  assign sext64 = {{32{sop[31]}}, sop};
  assign ext64  = is_logic ? {32'd0, zop} : sext64;
  assign lsh    = {96'd0, zop} << cnt;
  assign rsh    = {{64{ext64[63]}}, ext64} >> cnt;
  assign tshift = $signed(sext64) >>> (width - 7'd1 - {1'b0, cnt});

  always_comb begin
    raw   = go_left ? lsh[31:0] : rsh[31:0];
    c_new = 1'b0;
    if (cnt != 6'd0) c_new = go_left ? lsh[width] : ext64[cnt - 6'd1];
    v_new = 1'b0;
    if (go_left && !is_logic && full_ovf && cnt != 6'd0) begin
      if ({1'b0, cnt} >= width) v_new = zop != 32'd0;
      else                      v_new = !(tshift == 64'd0 || tshift == {64{1'b1}});
    end
    x_new = (cnt != 6'd0) ? c_new : x_in;
    case (sz)
      2'b00:   begin n_new = raw[7];  z_new = raw[7:0] == 8'd0;   merged = {dst_val[31:8], raw[7:0]};   end
      2'b01:   begin n_new = raw[15]; z_new = raw[15:0] == 16'd0; merged = {dst_val[31:16], raw[15:0]}; end
      default: begin n_new = raw[31]; z_new = raw == 32'd0;       merged = raw;                         end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= 32'd0;
      {flag_x, flag_n, flag_z, flag_v, flag_c} <= 5'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= merged;
        {flag_x, flag_n, flag_z, flag_v, flag_c} <= {x_new, n_new, z_new, v_new, c_new};
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{cnt_val[31:6], instr[15:12], instr[4], instr[2:0], rsh[127:32], lsh[127:33]};

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flag_c) && $stable(flag_x)));
  a_r4_byte_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[7:6] == 2'b00) |=> result[31:8] == $past(dst_val[31:8]));
  a_r10_mem_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[7:6] == 2'b11) |=> result[31:16] == $past(dst_val[31:16]));
  a_r6_zero_count: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[7:6] != 2'b11 && instr[5] && cnt_val[5:0] == 6'd0)
      |=> (!flag_c && !flag_v && flag_x == $past(x_in)));
  a_r6_x_tracks_c: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(instr[7:6] != 2'b11 && instr[5] && cnt_val[5:0] == 6'd0)) |=> flag_x == flag_c);
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (instr[3] || !instr[8] || !full_ovf)) |=> !flag_v);
  a_r7_long_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[7:6] == 2'b10) |=> (flag_z == (result == 32'd0) && flag_n == result[31]));

endmodule

// File: tb/sim_shift_cc_unit.sv
`timescale 1ns/1ps
module sim_shift_cc_unit;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, x_in = 1'b0, full_ovf = 1'b1;
  logic [15:0] instr = 16'd0;
  logic [31:0] dst_val = 32'd0, cnt_val = 32'd0;
  logic out_valid, flag_x, flag_n, flag_z, flag_v, flag_c;
  logic [31:0] result;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] e_r = 32'd0;
  logic e_x = 0, e_n = 0, e_z = 0, e_v = 0, e_c = 0;

  always #2 clk = ~clk;

  shift_cc_unit u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .dst_val(dst_val),
    .cnt_val(cnt_val), .x_in(x_in), .full_ovf(full_ovf), .out_valid(out_valid), .result(result),
    .flag_x(flag_x), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c));

  function automatic logic [15:0] mk(bit left, bit logi, bit [1:0] sz, bit regc, bit [2:0] imm);
    return {4'hE, imm, left, sz, regc, 1'b0, logi, 3'b000};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] ins, input logic [31:0] d, cs, input logic xi, fo);
    bit mem = ins[7:6] == 2'b11;
    int w = mem ? 16 : (ins[7:6] == 2'b00 ? 8 : (ins[7:6] == 2'b01 ? 16 : 32));
    int n;
    logic [31:0] mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    logic [31:0] val = d & mask;
    logic msb0, cv = 0, vv = 0, fill;
    if (mem) n = 1;
    else if (ins[5]) n = cs % 64;
    else n = (ins[11:9] == 0) ? 8 : int'(ins[11:9]);
    msb0 = val[w-1];
    for (int i = 0; i < n; i++) begin
      if (ins[8]) begin
        cv = val[w-1];
        val = (val << 1) & mask;
        if (val[w-1] != msb0) vv = 1;
      end else begin
        cv = val[0];
        fill = ins[3] ? 1'b0 : val[w-1];
        val = val >> 1;
        if (fill) val[w-1] = 1'b1;
      end
    end
    e_r = (d & ~mask) | val;
    e_c = (n == 0) ? 1'b0 : cv;
    e_x = (n == 0) ? xi : cv;
    e_v = ins[8] && !ins[3] && fo && vv;
    e_n = val[w-1];
    e_z = val == 0;
  endtask

  task automatic compare(string tag);
    chk(result == e_r, tag, "result", result, e_r);
    chk(flag_c == e_c, tag, "C", 32'(flag_c), 32'(e_c));
    chk(flag_x == e_x, tag, "X", 32'(flag_x), 32'(e_x));
    chk(flag_v == e_v, tag, "V", 32'(flag_v), 32'(e_v));
    chk(flag_n == e_n && flag_z == e_z, tag, "NZ", {30'd0, flag_n, flag_z}, {30'd0, e_n, e_z});
  endtask

  task automatic op(logic [15:0] ins, logic [31:0] d, logic [31:0] cs, logic xi, logic fo, string tag);
    instr = ins; dst_val = d; cnt_val = cs; x_in = xi; full_ovf = fo; in_valid = 1'b1;
    model(ins, d, cs, xi, fo);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, tag, "out_valid", 32'(out_valid), 32'd1);
    compare(tag);
  endtask

  task automatic idle(string tag);
    instr = 16'hFFFF; dst_val = 32'h1234_5678; cnt_val = 32'd3; x_in = ~x_in;
    @(negedge clk);
    chk(out_valid == 1'b0, tag, "out_valid idle", 32'(out_valid), 32'd0);
    compare(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && result == 0 && {flag_x, flag_n, flag_z, flag_v, flag_c} == 0,
        "R11", "reset state", result, 32'd0);
    rst = 1'b0;
    op(mk(1, 1, 2'b00, 0, 3'd0), 32'hAAAA_AA81, 0, 0, 1, "R2 imm 0 means 8");
    op(mk(0, 1, 2'b01, 0, 3'd3), 32'h0000_8009, 0, 0, 1, "R2 imm 3");
    op(mk(1, 1, 2'b10, 1, 3'd0), 32'hFFFF_FFFF, 40, 0, 1, "R3 count beyond long");
    op(mk(0, 0, 2'b10, 1, 3'd0), 32'h8000_0000, 63, 0, 1, "R3 asr 63 fill");
    op(mk(0, 1, 2'b10, 1, 3'd0), 32'h0000_00F0, 67, 1, 1, "R3 modulo 64");
    op(mk(0, 0, 2'b00, 0, 3'd2), 32'h5A5A_5A86, 0, 0, 1, "R4 byte upper kept");
    op(mk(1, 1, 2'b01, 1, 3'd0), 32'h1234_8001, 16, 0, 1, "R5 carry at width");
    op(mk(1, 1, 2'b01, 1, 3'd0), 32'h0000_FFFF, 17, 1, 1, "R5 carry beyond width");
    op(mk(1, 0, 2'b10, 1, 3'd0), 32'hC000_0001, 64, 1, 1, "R6 zero reg count");
    op(mk(0, 1, 2'b00, 0, 3'd1), 32'h0000_0001, 0, 0, 1, "R7 zero result");
    op(mk(1, 0, 2'b00, 0, 3'd1), 32'h0000_0040, 0, 0, 1, "R8 sign change");
    op(mk(1, 0, 2'b00, 0, 3'd1), 32'h0000_00C0, 0, 0, 1, "R8 sign kept");
    op(mk(1, 0, 2'b00, 1, 3'd0), 32'h0000_00FF, 8, 0, 1, "R8 count at width");
    op(mk(1, 0, 2'b00, 1, 3'd0), 32'h0000_0040, 1, 0, 0, "R9 reduced mode");
    op(mk(1, 1, 2'b00, 0, 3'd1), 32'h0000_0040, 0, 0, 1, "R9 logical");
    op(mk(1, 0, 2'b11, 1, 3'd5), 32'hDEAD_4001, 9, 0, 1, "R10 mem left");
    op(mk(0, 0, 2'b11, 0, 3'd7), 32'hBEEF_8001, 9, 0, 1, "R10 mem asr");
    op(mk(0, 1, 2'b11, 0, 3'd2), 32'h0000_0003, 0, 1, 1, "R1 mem lsr");
    idle("R11 hold");
    idle("R11 hold");
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ins = {4'hE, 12'($urandom)};
      if ($urandom_range(0, 3) == 0) idle("R11 idle");
      op(ins, $urandom, $urandom, 1'($urandom), 1'($urandom), "R1 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule